// File: doc/BRIEF.md
# Byte-Sequenced I2C Master Register Block

This block is the software-facing half of an I2C master. A processor programs it through five 8-bit registers on a small memory-mapped access port. The registers are control, status, own-address, data and line-control. From these accesses the block builds a stream of byte-level commands (start-with-address, write byte, read byte, stop). It hands each command to a separate bus engine that handles the wire timing. When the engine reports completion, the block records the acknowledge result or the received byte in its registers.

Software sets the pace of the transfer. After each address or data phase the block raises a level interrupt, if enabled, and holds a pending flag. The next byte moves when software clears that flag, writes the data register, or reads it. A start is issued by writing the status register with the start bit set. The slave address and direction are taken from the data register at that moment.

The engine accepts one command at a time. Any action that software triggers while a command is still outstanding waits in a one-entry slot until the engine reports done.

Top module: `i2c_host_regs`

## Requirements
- R1: After reset, control, status and line-control read 0x00, data and own-address read 0xFF, the interrupt output is low, and the bus is treated as free.
- R2: Registers sit at byte offsets control 0x00, status 0x04, own-address 0x08, data 0x0C and line-control 0x10. Line-control stores any written value. Other offsets read 0x00.
- R3: A write to own-address takes effect only while status bit 4 (output enable) is 0. Otherwise the register keeps its value.
- R4: A write to data is accepted only while status bit 4 is 1, and it marks the bus free.
- R5: The engine command opcode is 0 start, 1 write, 2 read and 3 stop. For start and write, the command byte carries the data register value; for read and stop it is 0x00. A status write with bit 7 = 1, bit 4 = 1 and bit 5 = 1 clears status bit 0, sets busy (bit 5), marks the bus not free and issues start. With bit 7 = 0 no command is issued.
- R6: Each completed address or data phase sets control bit 4 (pending) and drives the interrupt high only when control bit 5 is 1.
- R7: A start or write that completes without acknowledge, while control bit 7 is 1, sets status bit 0. Starting a write or read clears status bit 0.
- R8: In master receive mode (status bits 7:6 = 2'b10), an acknowledged start is followed at once by a read. The received byte lands in the data register before pending is raised.
- R9: A control write that clears a set pending bit lowers the interrupt. If control bit 5 is then 0, busy clears. If busy stays set and the bus is free, the next byte starts in the current direction. If the bus is not free, pending and the interrupt rise again at once. A control write never sets pending.
- R10: In master transmit mode (status bits 7:6 = 2'b11), a data write made while busy is set and pending is clear sends that byte immediately.
- R11: A data read marks the bus free. In master receive mode, with busy set and pending clear, it starts the next read.
- R12: A status write in master mode with bit 4 = 1 and bit 5 = 0 issues stop and marks the bus free. Busy clears only if pending is clear.
- R13: Software cannot set or clear status bit 5 directly. A status write with bit 4 = 0 clears busy, clears pending, lowers the interrupt and marks the bus free.
- R14: The engine never receives a command while one is outstanding. A triggered action is held and issued in order after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| irq | output | 1 | Level interrupt, follows the pending bit |
| eng_cmd_vld | output | 1 | One-cycle command strobe to the bus engine |
| eng_cmd_op | output | 2 | Command opcode (start, write, read, stop) |
| eng_cmd_byte | output | 8 | Address or data byte for the command |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_ack | input | 1 | 1 = acknowledge seen for start or write |
| eng_rbyte | input | 8 | Byte received by a read command |

## Verification
The bench first targets the pending-clear path in all three of its outcomes: a fresh byte when the bus is free, an immediate re-raise when the bus is not free, and a busy drop when interrupts are disabled. A design that confused these would either send a stray byte or leave software waiting on an interrupt that never comes. It then sends a stop while pending is set and checks that busy survives. It also writes the busy bit from software in slave and output-disabled states; a wrong design would launch a start nobody asked for. Finally it issues a data write directly behind a start. A block without the hold slot would strobe the engine twice, and the scoreboard would catch either the overlap or the out-of-order byte.

// File: rtl/ihc_pkg.sv
package ihc_pkg;
  localparam int REG_W = 8;
  localparam int NREG  = 5;

  // register indices (byte offset = index * 4)
  localparam int RI_CTRL = 0;
  localparam int RI_STAT = 1;
  localparam int RI_OADR = 2;
  localparam int RI_DATA = 3;
  localparam int RI_LINE = 4;

  // control bits
  localparam int CB_ACKCHK = 7;
  localparam int CB_IE     = 5;
  localparam int CB_PEND   = 4;

  // status bits
  localparam int SB_BUSY = 5;
  localparam int SB_OE   = 4;
  localparam int SB_NACK = 0;

  localparam logic [1:0] MODE_MRX = 2'b10;
  localparam logic [1:0] MODE_MTX = 2'b11;

  localparam logic [REG_W-1:0] RST_ONES = {REG_W{1'b1}};

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } eng_op_e;
endpackage

// File: rtl/ihc_addr_dec.sv
module ihc_addr_dec #(
  parameter int ADDR_W = 5,
  parameter int NSEL   = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NSEL-1:0]   hit
);
  localparam int STRIDE = 4;

  generate
    for (genvar g = 0; g < NSEL; g++) begin : g_hit
      localparam logic [ADDR_W-1:0] OFS = ADDR_W'(g * STRIDE);
      assign hit[g] = (addr == OFS);
    end
  endgenerate
endmodule

// File: rtl/ihc_cmd_slot.sv
module ihc_cmd_slot
  import ihc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_vld,
  input  eng_op_e          enq_op,
  input  logic [REG_W-1:0] enq_byte,
  input  logic             eng_done,
  output logic             cmd_vld,
  output eng_op_e          cmd_op,
  output logic [REG_W-1:0] cmd_byte,
  output eng_op_e          done_op
);
  logic             slot_vld_q, slot_vld_d;
  eng_op_e          slot_op_q, slot_op_d;
  logic [REG_W-1:0] slot_byte_q, slot_byte_d;
  logic             infl_q, infl_d;
  eng_op_e          infl_op_q, infl_op_d;
  logic             issue;

  assign issue = slot_vld_q & ~infl_q;

  always_comb begin
    slot_vld_d  = slot_vld_q;
    slot_op_d   = slot_op_q;
    slot_byte_d = slot_byte_q;
    infl_d      = infl_q;
    infl_op_d   = infl_op_q;
    if (issue) begin
      slot_vld_d = 1'b0;
      infl_d     = 1'b1;
      infl_op_d  = slot_op_q;
    end else if (eng_done) begin
      infl_d = 1'b0;
    end
    if (enq_vld) begin
      slot_vld_d  = 1'b1;
      slot_op_d   = enq_op;
      slot_byte_d = enq_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_vld_q  <= 1'b0;
      slot_op_q   <= OP_START;
      slot_byte_q <= '0;
      infl_q      <= 1'b0;
      infl_op_q   <= OP_START;
    end else begin
      slot_vld_q  <= slot_vld_d;
      slot_op_q   <= slot_op_d;
      slot_byte_q <= slot_byte_d;
      infl_q      <= infl_d;
      infl_op_q   <= infl_op_d;
    end
  end

  assign cmd_vld  = issue;
  assign cmd_op   = slot_op_q;
  assign cmd_byte = slot_byte_q;
  assign done_op  = infl_op_q;
endmodule

// File: rtl/ihc_regs.sv
module ihc_regs
  import ihc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_sel,
  input  logic             acc_wr,
  input  logic [NREG-1:0]  hit,
  input  logic [REG_W-1:0] wdata,
  input  logic             done,
  input  eng_op_e          done_op,
  input  logic             done_ack,
  input  logic [REG_W-1:0] done_byte,
  output logic [REG_W-1:0] rdata,
  output logic             irq,
  output logic             enq_vld,
  output eng_op_e          enq_op,
  output logic [REG_W-1:0] enq_byte,
  output logic [REG_W-1:0] stat_o,
  output logic [REG_W-1:0] oadr_o
);
  logic [REG_W-1:0] con_q, con_d;
  logic [REG_W-1:0] stat_q, stat_d;
  logic [REG_W-1:0] oadr_q, oadr_d;
  logic [REG_W-1:0] ds_q, ds_d;
  logic [REG_W-1:0] lc_q, lc_d;
  logic             free_q, free_d;
  logic             wr_en, rd_en;
  logic             raise;

  assign wr_en = acc_sel & acc_wr;
  assign rd_en = acc_sel & ~acc_wr;

  always_comb begin
    con_d    = con_q;
    stat_d   = stat_q;
    oadr_d   = oadr_q;
    ds_d     = ds_q;
    lc_d     = lc_q;
    free_d   = free_q;
    enq_vld  = 1'b0;
    enq_op   = OP_START;
    enq_byte = '0;
    raise    = 1'b0;

    // ---------------- register writes ----------------
    if (wr_en && hit[RI_CTRL]) begin
      con_d          = wdata;
      con_d[CB_PEND] = con_q[CB_PEND];
      if (con_q[CB_PEND] && !wdata[CB_PEND]) begin
        con_d[CB_PEND] = 1'b0;
        if (!con_d[CB_IE]) stat_d[SB_BUSY] = 1'b0;
        if (stat_d[SB_BUSY]) begin
          if (free_q) begin
            if (stat_q[7:6] == MODE_MTX) begin
              stat_d[SB_NACK] = 1'b0;
              free_d          = 1'b0;
              enq_vld         = 1'b1;
              enq_op          = OP_WRITE;
              enq_byte        = ds_q;
            end else if (stat_q[7:6] == MODE_MRX) begin
              stat_d[SB_NACK] = 1'b0;
              free_d          = 1'b0;
              enq_vld         = 1'b1;
              enq_op          = OP_READ;
            end
          end else begin
            con_d[CB_PEND] = 1'b1;
          end
        end
      end
    end

    if (wr_en && hit[RI_STAT]) begin
      stat_d          = wdata;
      stat_d[SB_BUSY] = stat_q[SB_BUSY];
      if (!wdata[SB_OE]) begin
        stat_d[SB_BUSY] = 1'b0;
        free_d          = 1'b1;
        con_d[CB_PEND]  = 1'b0;
      end else if (wdata[7]) begin
        if (wdata[SB_BUSY]) begin
          stat_d[SB_NACK] = 1'b0;
          stat_d[SB_BUSY] = 1'b1;
          free_d          = 1'b0;
          enq_vld         = 1'b1;
          enq_op          = OP_START;
          enq_byte        = ds_q;
        end else begin
          enq_vld = 1'b1;
          enq_op  = OP_STOP;
          if (!con_q[CB_PEND]) stat_d[SB_BUSY] = 1'b0;
          free_d = 1'b1;
        end
      end
    end

    if (wr_en && hit[RI_OADR] && !stat_q[SB_OE]) oadr_d = wdata;

    if (wr_en && hit[RI_DATA] && stat_q[SB_OE]) begin
      ds_d   = wdata;
      free_d = 1'b1;
      if (stat_q[7:6] == MODE_MTX && stat_q[SB_BUSY] && !con_q[CB_PEND]) begin
        stat_d[SB_NACK] = 1'b0;
        free_d          = 1'b0;
        enq_vld         = 1'b1;
        enq_op          = OP_WRITE;
        enq_byte        = wdata;
      end
    end

    if (wr_en && hit[RI_LINE]) lc_d = wdata;

    // ---------------- data read side effect ----------------
    if (rd_en && hit[RI_DATA]) begin
      free_d = 1'b1;
      if (stat_q[7:6] == MODE_MRX && stat_q[SB_BUSY] && !con_q[CB_PEND]) begin
        stat_d[SB_NACK] = 1'b0;
        free_d          = 1'b0;
        enq_vld         = 1'b1;
        enq_op          = OP_READ;
      end
    end

    // ---------------- engine completion ----------------
    if (done) begin
      case (done_op)
        OP_START: begin
          if (!done_ack && con_d[CB_ACKCHK]) begin
            stat_d[SB_NACK] = 1'b1;
            raise           = 1'b1;
          end else if (stat_d[7:6] == MODE_MRX) begin
            stat_d[SB_NACK] = 1'b0;
            enq_vld         = 1'b1;
            enq_op          = OP_READ;
            enq_byte        = '0;
          end else begin
            raise = 1'b1;
          end
        end
        OP_WRITE: begin
          if (!done_ack && con_d[CB_ACKCHK]) stat_d[SB_NACK] = 1'b1;
          raise = 1'b1;
        end
        OP_READ: begin
          ds_d  = done_byte;
          raise = 1'b1;
        end
        default: ;
      endcase
    end
    if (raise && con_d[CB_IE]) con_d[CB_PEND] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      con_q  <= '0;
      stat_q <= '0;
      oadr_q <= RST_ONES;
      ds_q   <= RST_ONES;
      lc_q   <= '0;
      free_q <= 1'b1;
    end else begin
      con_q  <= con_d;
      stat_q <= stat_d;
      oadr_q <= oadr_d;
      ds_q   <= ds_d;
      lc_q   <= lc_d;
      free_q <= free_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit[RI_CTRL]) rdata = con_q;
    if (hit[RI_STAT]) rdata = stat_q;
    if (hit[RI_OADR]) rdata = oadr_q;
    if (hit[RI_DATA]) rdata = ds_q;
    if (hit[RI_LINE]) rdata = lc_q;
  end

  assign irq    = con_q[CB_PEND];
  assign stat_o = stat_q;
  assign oadr_o = oadr_q;
endmodule

// File: rtl/i2c_host_regs.sv
module i2c_host_regs
  import ihc_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq,
  output logic              eng_cmd_vld,
  output logic [1:0]        eng_cmd_op,
  output logic [REG_W-1:0]  eng_cmd_byte,
  input  logic              eng_done,
  input  logic              eng_ack,
  input  logic [REG_W-1:0]  eng_rbyte
);
  logic [NREG-1:0]  hit;
  logic             enq_vld;
  eng_op_e          enq_op;
  logic [REG_W-1:0] enq_byte;
  eng_op_e          cmd_op;
  eng_op_e          done_op;
  logic [REG_W-1:0] stat_w;
  logic [REG_W-1:0] oadr_w;

  ihc_addr_dec #(.ADDR_W(ADDR_W), .NSEL(NREG)) u_dec (
    .addr (bus_addr),
    .hit  (hit)
  );

  ihc_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_sel   (bus_sel),
    .acc_wr    (bus_wr),
    .hit       (hit),
    .wdata     (bus_wdata),
    .done      (eng_done),
    .done_op   (done_op),
    .done_ack  (eng_ack),
    .done_byte (eng_rbyte),
    .rdata     (bus_rdata),
    .irq       (irq),
    .enq_vld   (enq_vld),
    .enq_op    (enq_op),
    .enq_byte  (enq_byte),
    .stat_o    (stat_w),
    .oadr_o    (oadr_w)
  );

  ihc_cmd_slot u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .enq_vld  (enq_vld),
    .enq_op   (enq_op),
    .enq_byte (enq_byte),
    .eng_done (eng_done),
    .cmd_vld  (eng_cmd_vld),
    .cmd_op   (cmd_op),
    .cmd_byte (eng_cmd_byte),
    .done_op  (done_op)
  );

  assign eng_cmd_op = cmd_op;
endmodule

// File: rtl/ihc_chk.sv
module ihc_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_sel,
  input logic              acc_wr,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              wd7,
  input logic              wd4,
  input logic              irq,
  input logic              eng_cmd_vld,
  input logic              eng_done,
  input logic              stat_busy,
  input logic              stat_oe,
  input logic [7:0]        oadr
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_OADR = ADDR_W'(8);

  logic infl_q;
  logic w_ctrl, w_stat, w_oadr;

  assign w_ctrl = acc_sel && acc_wr && (acc_addr == A_CTRL);
  assign w_stat = acc_sel && acc_wr && (acc_addr == A_STAT);
  assign w_oadr = acc_sel && acc_wr && (acc_addr == A_OADR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           infl_q <= 1'b0;
    else if (eng_cmd_vld) infl_q <= 1'b1;
    else if (eng_done)    infl_q <= 1'b0;
  end

  p_single_cmd_r14: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cmd_vld |-> !infl_q)
    else $error("command issued while engine busy");

  p_ctrl_no_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (w_ctrl && !irq && !eng_done) |=> !irq)
    else $error("control write raised pending");

  p_oe_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (w_stat && !wd4 && !eng_done) |=> (!irq && !stat_busy))
    else $error("output disable left busy or irq");

  p_busy_no_sw_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (w_stat && !stat_busy && !wd7) |=> !stat_busy)
    else $error("busy set outside master start");

  p_oadr_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (w_oadr && stat_oe) |=> $stable(oadr))
    else $error("own-address changed while output enabled");
endmodule

bind i2c_host_regs ihc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_sel     (bus_sel),
  .acc_wr      (bus_wr),
  .acc_addr    (bus_addr),
  .wd7         (bus_wdata[7]),
  .wd4         (bus_wdata[4]),
  .irq         (irq),
  .eng_cmd_vld (eng_cmd_vld),
  .eng_done    (eng_done),
  .stat_busy   (stat_w[5]),
  .stat_oe     (stat_w[4]),
  .oadr        (oadr_w)
);

// File: tb/i2c_host_regs_tb.sv
module i2c_host_regs_tb;
  localparam int LAT = 3;
  localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_OADR = 5'h08,
                         A_DATA = 5'h0C, A_LINE = 5'h10;
  localparam logic [1:0] C_START = 2'd0, C_WRITE = 2'd1, C_READ = 2'd2, C_STOP = 2'd3;

  logic clk, rst_n;
  logic bus_sel, bus_wr;
  logic [4:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic irq, eng_cmd_vld, eng_done, eng_ack;
  logic [1:0] eng_cmd_op;
  logic [7:0] eng_cmd_byte, eng_rbyte;

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;
  logic tb_ack = 1'b1;
  logic [7:0] tb_rbyte = 8'h00;

  typedef struct packed { logic [1:0] op; logic [7:0] b; } exp_t;
  exp_t exp_q[$];

  i2c_host_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .eng_cmd_vld(eng_cmd_vld), .eng_cmd_op(eng_cmd_op),
    .eng_cmd_byte(eng_cmd_byte), .eng_done(eng_done), .eng_ack(eng_ack),
    .eng_rbyte(eng_rbyte)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic expect_cmd(input logic [1:0] op, input logic [7:0] b);
    exp_t e;
    e.op = op; e.b = b;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bus engine model and command scoreboard (R5, R14)
  initial begin
    int cnt;
    bit busy;
    exp_t e;
    cnt = 0; busy = 0;
    eng_done = 1'b0; eng_ack = 1'b0; eng_rbyte = 8'h00;
    forever begin
      @(negedge clk);
      eng_done = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          eng_done = 1'b1; eng_ack = tb_ack; eng_rbyte = tb_rbyte; busy = 0;
        end
      end
      if (rst_n && eng_cmd_vld) begin
        n_chk++;
        if (busy) begin
          n_fail++;
          $display("FAIL R14 command while busy actual=1 expected=0");
        end
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R5 unexpected command actual=%0d/%02h expected=none",
                   eng_cmd_op, eng_cmd_byte);
        end else begin
          e = exp_q.pop_front();
          if (eng_cmd_op !== e.op || eng_cmd_byte !== e.b) begin
            n_fail++;
            $display("FAIL R5 command actual=%0d/%02h expected=%0d/%02h",
                     eng_cmd_op, eng_cmd_byte, e.op, e.b);
          end
        end
        busy = 1; cnt = LAT;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    idle(4);
    rst_n = 1'b1;
    idle(2);

    // R1 reset values
    rd(A_CTRL, v); chk("R1 ctrl", v, 8'h00);
    rd(A_STAT, v); chk("R1 stat", v, 8'h00);
    rd(A_OADR, v); chk("R1 oadr", v, 8'hFF);
    rd(A_DATA, v); chk("R1 data", v, 8'hFF);
    rd(A_LINE, v); chk("R1 line", v, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // R2 line control and unmapped offset
    wr(A_LINE, 8'h5A); rd(A_LINE, v); chk("R2 line", v, 8'h5A);
    rd(5'h14, v); chk("R2 unmapped", v, 8'h00);

    // R3 own-address lock, R13 busy not writable in slave mode
    wr(A_OADR, 8'h33); rd(A_OADR, v); chk("R3 oadr open", v, 8'h33);
    wr(A_STAT, 8'h30); rd(A_STAT, v); chk("R13 busy sw", v, 8'h10);
    wr(A_OADR, 8'h77); rd(A_OADR, v); chk("R3 oadr locked", v, 8'h33);

    // R4 data write gating
    wr(A_STAT, 8'h00); wr(A_DATA, 8'h12); rd(A_DATA, v); chk("R4 data blocked", v, 8'hFF);
    wr(A_STAT, 8'h10); wr(A_DATA, 8'hA4); rd(A_DATA, v); chk("R4 data accepted", v, 8'hA4);

    // R5/R6 master transmit start with interrupts on
    wr(A_CTRL, 8'hA0);
    tb_ack = 1'b1; expect_cmd(C_START, 8'hA4);
    wr(A_STAT, 8'hF0);
    idle(12);
    chk("R6 irq after start", {7'd0, irq}, 8'h01);
    rd(A_STAT, v); chk("R5 stat busy", v, 8'hF0);
    rd(A_CTRL, v); chk("R6 pending bit", v, 8'hB0);

    // R9 clear pending with bus free sends next byte; R7 nack
    wr(A_DATA, 8'h3C);
    idle(4);
    tb_ack = 1'b0; expect_cmd(C_WRITE, 8'h3C);
    wr(A_CTRL, 8'hA0);
    chk("R9 irq lowered", {7'd0, irq}, 8'h00);
    idle(12);
    chk("R6 irq after write", {7'd0, irq}, 8'h01);
    rd(A_STAT, v); chk("R7 nack flag", v, 8'hF1);

    // R9 bus not free -> re-raise
    wr(A_CTRL, 8'hA0);
    chk("R9 reraise", {7'd0, irq}, 8'h01);
    idle(6);

    // R9 next byte, R7 flag cleared
    wr(A_DATA, 8'h55);
    tb_ack = 1'b1; expect_cmd(C_WRITE, 8'h55);
    wr(A_CTRL, 8'hA0);
    idle(12);
    rd(A_STAT, v); chk("R7 flag cleared", v, 8'hF0);

    // R12 stop while pending keeps busy; R9 ie off drops busy
    expect_cmd(C_STOP, 8'h00);
    wr(A_STAT, 8'hD0);
    idle(8);
    rd(A_STAT, v); chk("R12 busy kept", v, 8'hF0);
    wr(A_CTRL, 8'h80);
    chk("R9 irq low ie off", {7'd0, irq}, 8'h00);
    rd(A_STAT, v); chk("R9 busy dropped", v, 8'hD0);

    // R6 gating, R10 immediate send, R12 stop clears busy
    expect_cmd(C_START, 8'h55);
    wr(A_STAT, 8'hF0);
    idle(12);
    chk("R6 no irq when disabled", {7'd0, irq}, 8'h00);
    rd(A_CTRL, v); chk("R6 pending clear", v, 8'h80);
    expect_cmd(C_WRITE, 8'h66);
    wr(A_DATA, 8'h66);
    idle(12);
    expect_cmd(C_STOP, 8'h00);
    wr(A_STAT, 8'hD0);
    idle(8);
    rd(A_STAT, v); chk("R12 busy cleared", v, 8'hD0);

    // R14 back-to-back actions held in order
    expect_cmd(C_START, 8'h66);
    expect_cmd(C_WRITE, 8'h99);
    wr(A_STAT, 8'hF0);
    wr(A_DATA, 8'h99);
    idle(20);
    rd(A_STAT, v); chk("R14 stat after hold", v, 8'hF0);
    expect_cmd(C_STOP, 8'h00);
    wr(A_STAT, 8'hD0);
    idle(8);

    // R8 master receive with interrupts
    wr(A_CTRL, 8'hA0);
    wr(A_DATA, 8'hA5);
    tb_rbyte = 8'hC3;
    expect_cmd(C_START, 8'hA5); expect_cmd(C_READ, 8'h00);
    wr(A_STAT, 8'hB0);
    idle(20);
    chk("R8 irq after read", {7'd0, irq}, 8'h01);
    rd(A_DATA, v); chk("R8 first byte", v, 8'hC3);
    tb_rbyte = 8'h5E; expect_cmd(C_READ, 8'h00);
    wr(A_CTRL, 8'hA0);
    idle(12);
    rd(A_DATA, v); chk("R9 next read byte", v, 8'h5E);

    // R13 output disable
    wr(A_STAT, 8'h20);
    chk("R13 irq low", {7'd0, irq}, 8'h00);
    rd(A_STAT, v); chk("R13 stat cleared", v, 8'h00);

    // R11 read-triggered receive, interrupts off
    wr(A_CTRL, 8'h80);
    wr(A_STAT, 8'h10);
    wr(A_DATA, 8'hA5);
    tb_rbyte = 8'h11;
    expect_cmd(C_START, 8'hA5); expect_cmd(C_READ, 8'h00);
    wr(A_STAT, 8'hB0);
    idle(20);
    chk("R6 no irq rx", {7'd0, irq}, 8'h00);
    tb_rbyte = 8'h22; expect_cmd(C_READ, 8'h00);
    rd(A_DATA, v); chk("R8 rx byte", v, 8'h11);
    idle(12);
    expect_cmd(C_READ, 8'h00);
    rd(A_DATA, v); chk("R11 read triggered", v, 8'h22);
    idle(12);
    expect_cmd(C_STOP, 8'h00);
    wr(A_STAT, 8'h90);
    idle(10);

    chk("R14 all commands seen", 8'(exp_q.size()), 8'h00);
    finish_run();
  end
endmodule